// File: doc/BRIEF.md
# Leading-One Word Normalizer

This block takes a 32-bit unsigned word and shifts it left until its highest set bit sits in the most significant position. It reports the shifted word and the number of positions moved. A caller presents a word with a one-cycle start request. Some time later the block answers with a one-cycle done pulse. The shifted word and the count stay on the outputs until the next answer.

A mode input, sampled together with the start request, selects one of two engines:

- **Walking engine (mode 0).** It moves the word one bit per clock. Its latency grows with the number of leading zeros. Words that are zero or already normalized finish at once with a count of 0.
- **Halving engine (mode 1).** It tests progressively narrower top slices of the word (16, 8, 4, 2, then 1 bit). Any slice that is all zero is shifted out. The halving engine always takes five clocks, and it reports a count of 32 for a zero word.

Top module: `word_normalizer`

## Requirements
- R1: While reset is held and in the first cycle after it, done_o is 0, norm_o is 0 and count_o is 0.
- R2: In walking mode (mode_i = 0), a word that is zero or has bit 31 set finishes with count_o = 0 and norm_o equal to the word. done_o rises one clock after the start edge.
- R3: In walking mode, any other word finishes with count_o equal to its number of leading zeros and norm_o equal to the word shifted left by that count. done_o rises count_o + 1 clocks after the start edge.
- R4: In walking mode the word 1 is the slowest case: count_o = 31, norm_o = 0x80000000, and done_o rises 32 clocks after the start edge.
- R5: In halving mode (mode_i = 1), a nonzero word finishes with count_o equal to its number of leading zeros and norm_o equal to the word shifted left by that count.
- R6: In halving mode a zero word finishes with count_o = 32 and norm_o = 0.
- R7: In halving mode done_o rises exactly 5 clocks after the start edge, whatever the data.
- R8: done_o is high for one cycle per accepted request. norm_o and count_o change only in a cycle where done_o is high and hold their values otherwise.
- R9: A start_i request made while an operation is in progress is ignored. It produces no extra done_o pulse and does not alter the result of the operation in flight.
- R10: mode_i and value_i are captured only on the clock edge where a start request is accepted. Changing them later has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a normalization |
| mode_i | input | 1 | Engine select: 0 walking, 1 halving |
| value_i | input | 32 | Word to normalize |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| norm_o | output | 32 | Normalized word |
| count_o | output | 6 | Number of positions shifted (0 to 32) |

## Verification
The hardest situation to reach from the ports is a second start request arriving while the walking engine is partway through a long run. That request also carries a different mode and word, which must not leak into the result. The stimulus starts the word 1 in walking mode, then repeatedly pulses start_i with the opposite mode and other words during the 32-clock run. It then checks that exactly one answer appears, with the values of the first request, and that no further done pulse follows. The two engines are told apart through the zero word (count 0 versus 32) and through the fixed versus data-dependent latency.

// File: rtl/wnorm_pkg.sv
package wnorm_pkg;

    parameter int DATA_W = 32;
    localparam int CNT_W      = $clog2(DATA_W + 1);
    localparam int NUM_STAGES = $clog2(DATA_W);
    localparam int STG_W      = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

    typedef enum logic {
        MODE_WALK  = 1'b0,
        MODE_HALVE = 1'b1
    } nmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } nstate_e;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [CNT_W-1:0]  cnt;
    } work_t;

    // A word needs no further walking when it is zero or already has its top bit set.
    function automatic logic walk_settled(input logic [DATA_W-1:0] v);
        return (v == '0) || v[DATA_W-1];
    endfunction

endpackage

// File: rtl/wnorm_walk_step.sv
module wnorm_walk_step
    import wnorm_pkg::*;
(
    input  work_t cur,
    output work_t nxt,
    output logic  fin
);
    always_comb begin
        fin     = walk_settled(cur.val);
        nxt.val = cur.val << 1;
        nxt.cnt = cur.cnt + CNT_W'(1);
    end
endmodule

// File: rtl/wnorm_halve_step.sv
module wnorm_halve_step
    import wnorm_pkg::*;
(
    input  work_t             cur,
    input  logic [STG_W-1:0]  idx,
    output work_t             nxt
);
    work_t cand [NUM_STAGES];

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        localparam int SW = DATA_W >> (s + 1);
        if (s == NUM_STAGES - 1) begin : g_last
            always_comb begin
                cand[s] = cur;
                if (!cur.val[DATA_W-1]) begin
                    cand[s].val = cur.val << 1;
                    cand[s].cnt = cur.cnt + CNT_W'(1);
                    if ((cur.val << 1) == '0) begin
                        cand[s].cnt = CNT_W'(DATA_W);
                    end
                end
            end
        end else begin : g_mid
            always_comb begin
                cand[s] = cur;
                if (cur.val[DATA_W-1 -: SW] == '0) begin
                    cand[s].val = cur.val << SW;
                    cand[s].cnt = cur.cnt + CNT_W'(SW);
                end
            end
        end
    end

    always_comb begin
        nxt = cur;
        for (int k = 0; k < NUM_STAGES; k++) begin
            if (idx == STG_W'(k)) begin
                nxt = cand[k];
            end
        end
    end
endmodule

// File: rtl/word_normalizer.sv
module word_normalizer
    import wnorm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              done_o,
    output logic [DATA_W-1:0] norm_o,
    output logic [CNT_W-1:0]  count_o
);
    nstate_e           state_q;
    nmode_e            mode_q;
    logic [STG_W-1:0]  stage_q;
    work_t             work_q;
    work_t             res_q;
    logic              done_q;

    work_t walk_nxt;
    logic  walk_fin;
    work_t halve_nxt;

    wnorm_walk_step u_walk (
        .cur (work_q),
        .nxt (walk_nxt),
        .fin (walk_fin)
    );

    wnorm_halve_step u_halve (
        .cur (work_q),
        .idx (stage_q),
        .nxt (halve_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_WALK;
            stage_q <= '0;
            work_q  <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        work_q.val <= value_i;
                        work_q.cnt <= '0;
                        mode_q     <= nmode_e'(mode_i);
                        stage_q    <= '0;
                        state_q    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (mode_q == MODE_WALK) begin
                        if (walk_fin) begin
                            res_q   <= work_q;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            work_q <= walk_nxt;
                        end
                    end else begin
                        work_q <= halve_nxt;
                        if (stage_q == STG_W'(NUM_STAGES - 1)) begin
                            res_q   <= halve_nxt;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            stage_q <= stage_q + STG_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o  = done_q;
    assign norm_o  = res_q.val;
    assign count_o = res_q.cnt;
endmodule

// File: rtl/wnorm_checker.sv
module wnorm_checker
    import wnorm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              mode_i,
    input logic [DATA_W-1:0] value_i,
    input logic              done_o,
    input logic [DATA_W-1:0] norm_o,
    input logic [CNT_W-1:0]  count_o
);
    localparam int LAT_W = CNT_W + 1;

    logic             busy_q;
    logic             mode_seen_q;
    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            mode_seen_q <= 1'b0;
            lat_q       <= '0;
        end else if (!busy_q && start_i) begin
            busy_q      <= 1'b1;
            mode_seen_q <= mode_i;
            lat_q       <= '0;
        end else if (busy_q) begin
            lat_q <= lat_q + LAT_W'(1);
            if (done_o) busy_q <= 1'b0;
        end
    end

    // Sampled inputs carry no checkable intent beyond acceptance.
    logic unused_ok;
    assign unused_ok = ^value_i;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(norm_o) && $stable(count_o)));

    p_msb_set_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && norm_o != '0) |-> norm_o[DATA_W-1]);

    p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (count_o <= CNT_W'(DATA_W)));

    p_zero_count_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && norm_o == '0) |-> (count_o == '0 || count_o == CNT_W'(DATA_W)));

    p_halve_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_seen_q) |-> (lat_q == LAT_W'(NUM_STAGES)));

    p_walk_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !mode_seen_q) |-> (lat_q == {1'b0, count_o} + LAT_W'(1)));

    p_done_needs_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_q);
endmodule

bind word_normalizer wnorm_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .mode_i  (mode_i),
    .value_i (value_i),
    .done_o  (done_o),
    .norm_o  (norm_o),
    .count_o (count_o)
);

// File: tb/word_normalizer_tb_top.sv
module word_normalizer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        mode_i;
    logic [31:0] value_i;
    logic        done_o;
    logic [31:0] norm_o;
    logic [5:0]  count_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    word_normalizer dut_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (mode_i),
        .value_i (value_i),
        .done_o  (done_o),
        .norm_o  (norm_o),
        .count_o (count_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic int lead_zeros(input logic [31:0] v);
        int n = 0;
        for (int b = 31; b >= 0; b--) begin
            if (v[b]) return n;
            n++;
        end
        return 32;
    endfunction

    // Runs one operation and checks result, latency, pulse width and hold.
    task automatic run_op(input bit mode, input logic [31:0] v, input string req);
        int lz, exp_cnt, exp_lat, lat;
        logic [31:0] exp_norm;
        lz = lead_zeros(v);
        if (!mode) begin
            exp_cnt  = (v == 0 || v[31]) ? 0 : lz;
            exp_lat  = exp_cnt + 1;
        end else begin
            exp_cnt  = lz;
            exp_lat  = 5;
        end
        exp_norm = (exp_cnt >= 32) ? 32'h0 : (v << exp_cnt);
        @(negedge clk);
        start_i = 1'b1; mode_i = mode; value_i = v;
        @(posedge clk); #1;
        start_i = 1'b0;
        mode_i  = ~mode; value_i = ~v;   // later changes must not matter (R10)
        lat = 0;
        while (!done_o && lat < 60) begin
            @(posedge clk); #1;
            lat++;
        end
        check(lat == exp_lat, req, "latency", 32'(lat), 32'(exp_lat));
        check(count_o == 6'(exp_cnt), req, "count", {26'h0, count_o}, 32'(exp_cnt));
        check(norm_o == exp_norm, req, "norm", norm_o, exp_norm);
        @(posedge clk); #1;
        check(done_o == 1'b0, "R8", "done width", {31'h0, done_o}, 32'h0);
        check(norm_o == exp_norm && count_o == 6'(exp_cnt), "R8", "hold",
              norm_o, exp_norm);
    endtask

    task automatic t_reset;
        rst = 1'b1; start_i = 1'b0; mode_i = 1'b0; value_i = '0;
        repeat (3) @(posedge clk);
        #1;
        check(done_o == 0 && norm_o == 0 && count_o == 0, "R1", "in reset",
              norm_o, 32'h0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(done_o == 0 && norm_o == 0 && count_o == 0, "R1", "after reset",
              {26'h0, count_o}, 32'h0);
    endtask

    task automatic t_walk_trivial;   // R2
        run_op(1'b0, 32'h8000_0001, "R2");
        run_op(1'b0, 32'h0000_0000, "R2");
    endtask

    task automatic t_walk_general;   // R3
        run_op(1'b0, 32'h0001_0000, "R3");
        run_op(1'b0, 32'h00F0_0000, "R3");
        run_op(1'b0, 32'h4000_0000, "R3");
        run_op(1'b0, 32'h0000_0F0F, "R3");
    endtask

    task automatic t_walk_worst;     // R4
        run_op(1'b0, 32'h0000_0001, "R4");
    endtask

    task automatic t_halve;          // R5, R7, R10
        run_op(1'b1, 32'h0000_0001, "R5");
        run_op(1'b1, 32'h0001_0000, "R5");
        run_op(1'b1, 32'h8000_0000, "R7");
        run_op(1'b1, 32'h1234_5678, "R5");
        run_op(1'b1, 32'h0000_0003, "R10");
        run_op(1'b1, 32'h0080_0001, "R7");
    endtask

    task automatic t_halve_zero;     // R6
        run_op(1'b1, 32'h0000_0000, "R6");
    endtask

    task automatic t_busy_start;     // R9
        int lat, pulses;
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0; value_i = 32'h0000_0001;
        @(posedge clk); #1;
        start_i = 1'b0;
        lat = 0; pulses = 0;
        for (int c = 0; c < 70; c++) begin
            // poke start with other mode and data while busy
            start_i = (c % 3 == 0) && (c < 28);
            mode_i  = 1'b1;
            value_i = 32'h00FF_0000;
            @(posedge clk); #1;
            start_i = 1'b0;
            if (done_o) begin
                pulses++;
                if (pulses == 1) begin
                    lat = c + 1;
                    check(count_o == 6'd31 && norm_o == 32'h8000_0000, "R9",
                          "result kept", norm_o, 32'h8000_0000);
                end
            end
        end
        check(lat == 32, "R9", "latency kept", 32'(lat), 32'd32);
        check(pulses == 1, "R9", "single done", 32'(pulses), 32'd1);
    endtask

    initial begin
        t_reset();
        t_walk_trivial();
        t_walk_general();
        t_walk_worst();
        t_halve();
        t_halve_zero();
        t_busy_start();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule